// File: doc/BRIEF.md
# Speculative Load Address Tracking Queue

This block lets a core run loads ahead of program order and still look sequentially consistent to other cores. Each load enters a circular queue in program order and records its cache-block address when it executes. The entry stays there until the load retires. Stores are not tracked: the core issues and commits them in order, without speculation.

The block also watches the invalidations that the coherence fabric delivers when another core writes a block. If an invalidation names a block that a tracked load already read, that load may have returned a stale value. The block then raises a flush that names the oldest affected entry. That entry and everything younger are dropped from the queue, and the core re-executes from that load. Older loads stay tracked.

The retire pointer is the slot of the oldest tracked load. The allocation slot is the position the next load will take. Recovery itself belongs to the surrounding pipeline.

Top module: `ld_order_guard`

## Requirements
- R1: After reset the queue is empty: `ld_ready` is 1, `flush_valid` is 0, and both `head_slot` and `ld_slot` are 0.
- R2: Each accepted load takes the slot shown on `ld_slot`. The slot then advances by one, modulo 16, so slots are handed out in program order.
- R3: The queue holds 16 loads. With 16 tracked, `ld_ready` is 0, a presented load is not stored, and `ld_slot` does not move.
- R4: A commit frees the oldest entry and advances `head_slot` by one, modulo 16. A commit while the queue is empty has no effect.
- R5: Addresses are compared on bits 31 to 6, the 64-byte block. A snoop that differs from a tracked load only in bits 5 to 0 hits. A snoop to any other block raises no flush.
- R6: On a snoop hit, `flush_valid` is 1 for one cycle in the following cycle. `flush_slot` then gives the slot of the oldest tracked load in the snooped block.
- R7: A flush frees the flushed entry and all younger ones in the same edge. From the next cycle `ld_slot` equals the flushed slot. Older entries stay tracked, so a later snoop to one of them still flushes.
- R8: If a snoop hits the oldest entry in the same cycle that this entry commits, the commit wins and that entry raises no flush. A younger matching entry still flushes.
- R9: A load that has committed is no longer tracked. A snoop to its block no longer raises a flush.
- R10: A load presented in the same cycle as a snoop hit is younger than the flushed load and is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | A load executes and enters the queue |
| ld_addr | input | 32 | Byte address read by the load |
| ld_ready | output | 1 | Queue has room for a load |
| ld_slot | output | 4 | Slot the next accepted load takes |
| cm_valid | input | 1 | Oldest tracked load retires |
| head_slot | output | 4 | Slot of the oldest tracked load |
| snp_valid | input | 1 | Invalidation from another core |
| snp_addr | input | 32 | Address of the invalidated block |
| flush_valid | output | 1 | Mis-speculation detected |
| flush_slot | output | 4 | Oldest load to squash |

## Verification
The bench targets five corner cases.

- A snoop that differs from a load only inside the 64-byte block must still hit. A design comparing full addresses would miss it.
- With two loads of the same block, the older one must be flushed. A design that scans from the wrong end would name the younger one.
- When a snoop arrives together with the commit of that same load, no flush may follow. A design without commit priority would squash a load that has already retired.
- When a snoop arrives together with a new load, the new load must be dropped. A design that keeps it would leave a stale entry behind the flush point; a later snoop to a younger load's block then finds that stale entry, and the flush names the wrong slot.
- After the queue fills, an extra load must leave no trace, and commits must wrap the slots correctly.

// File: rtl/ld_order_guard.sv
module ld_order_guard #(
  parameter int DEPTH   = 16,
  parameter int ADDR_W  = 32,
  parameter int BLK_OFF = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_valid,
  input  logic [ADDR_W-1:0]         ld_addr,
  output logic                      ld_ready,
  output logic [$clog2(DEPTH)-1:0]  ld_slot,
  input  logic                      cm_valid,
  output logic [$clog2(DEPTH)-1:0]  head_slot,
  input  logic                      snp_valid,
  input  logic [ADDR_W-1:0]         snp_addr,
  output logic                      flush_valid,
  output logic [$clog2(DEPTH)-1:0]  flush_slot
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam int TAG_W = ADDR_W - BLK_OFF;

  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q, count, hit_age;
  logic [IDX_W-1:0] hit_idx, idx;
  logic             hit, cm_fire, ld_fire;
  logic             unused_offset_bits;

  assign unused_offset_bits = ^{ld_addr[BLK_OFF-1:0], snp_addr[BLK_OFF-1:0]};

  assign count     = tail_q - head_q;
  assign ld_ready  = count < PTR_W'(DEPTH);
  assign ld_slot   = tail_q[IDX_W-1:0];
  assign head_slot = head_q[IDX_W-1:0];
  assign cm_fire   = cm_valid && (count != '0);
  assign ld_fire   = ld_valid && ld_ready && !hit;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    hit_age = '0;
    idx     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_q[IDX_W-1:0] + IDX_W'(k);
      if (snp_valid && !hit && (PTR_W'(k) < count) && !(cm_fire && k == 0) &&
          tag_q[idx] == snp_addr[ADDR_W-1:BLK_OFF]) begin
        hit     = 1'b1;
        hit_idx = idx;
        hit_age = PTR_W'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q      <= '0;
      tail_q      <= '0;
      flush_valid <= 1'b0;
      flush_slot  <= '0;
    end else begin
      flush_valid <= hit;
      if (hit) flush_slot <= hit_idx;
      if (cm_fire) head_q <= head_q + 1'b1;
      if (hit) tail_q <= head_q + hit_age;
      else if (ld_fire) tail_q <= tail_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_fire) tag_q[tail_q[IDX_W-1:0]] <= ld_addr[ADDR_W-1:BLK_OFF];
  end
endmodule

// File: rtl/ld_order_guard_chk.sv
module ld_order_guard_chk #(
  parameter int DEPTH   = 16,
  parameter int ADDR_W  = 32,
  parameter int BLK_OFF = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ld_valid,
  input logic [ADDR_W-1:0]         ld_addr,
  input logic                      ld_ready,
  input logic [$clog2(DEPTH)-1:0]  ld_slot,
  input logic                      cm_valid,
  input logic [$clog2(DEPTH)-1:0]  head_slot,
  input logic                      snp_valid,
  input logic [ADDR_W-1:0]         snp_addr,
  input logic                      flush_valid,
  input logic [$clog2(DEPTH)-1:0]  flush_slot
);
  assert_flush_needs_snoop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(snp_valid));

  assert_flush_rewinds_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (ld_slot == flush_slot && ld_ready));

  assert_commit_beats_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && $past(cm_valid && (ld_slot != head_slot || !ld_ready)))
      |-> flush_slot != $past(head_slot));

  assert_head_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cm_valid) |-> head_slot == $past(head_slot));

  assert_full_holds_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ld_ready && !cm_valid) && !flush_valid |-> ld_slot == $past(ld_slot));
endmodule

bind ld_order_guard ld_order_guard_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BLK_OFF(BLK_OFF)) u_chk (.*);

// File: tb/ld_order_guard_bench.sv
`timescale 1ns/1ps
module ld_order_guard_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ld_valid = 0, cm_valid = 0, snp_valid = 0;
  logic [31:0] ld_addr = '0, snp_addr = '0;
  logic        ld_ready, flush_valid;
  logic [3:0]  ld_slot, head_slot, flush_slot;

  ld_order_guard u_ld_order_guard (.*);

  always #2.5 clk = ~clk;

  int          n_cmp = 0, n_bad = 0, mh = 0;
  logic [25:0] mq[$];
  int          exp_q[$];
  bit          done = 0;

  task automatic chk(input string r, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic logic [31:0] blk(input int n, input int off);
    return 32'(n * 64 + off);
  endfunction

  task automatic step(input bit lv, input logic [31:0] la, input bit cv,
                      input bit sv, input logic [31:0] sa);
    int p;
    bit c;
    @(negedge clk);
    chk("R2", ld_slot, (mh + mq.size()) % 16);
    chk("R4", head_slot, mh % 16);
    chk("R3", ld_ready, mq.size() < 16);
    ld_valid = lv; ld_addr = la; cm_valid = cv; snp_valid = sv; snp_addr = sa;
    @(posedge clk);
    c = cv && mq.size() > 0;
    p = -1;
    if (sv)
      for (int i = c ? 1 : 0; i < mq.size(); i++)
        if (p < 0 && mq[i] == sa[31:6]) p = i;
    if (p >= 0) begin
      exp_q.push_back((mh + p) % 16);
      if (c) begin void'(mq.pop_front()); mh++; p--; end
      while (mq.size() > p) void'(mq.pop_back());
    end else begin
      if (lv && mq.size() < 16) mq.push_back(la[31:6]);
      if (c) begin void'(mq.pop_front()); mh++; end
    end
  endtask

  task automatic idle();
    step(0, '0, 0, 0, '0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (flush_valid) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R6 actual=flush at slot %0d expected=no flush", flush_slot);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk("R6", flush_slot, e);
        end
      end else if (exp_q.size() > 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6 actual=no flush expected=flush at slot %0d", exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: empty queue after reset
    chk("R1", ld_ready, 1); chk("R1", flush_valid, 0);
    chk("R1", head_slot, 0); chk("R1", ld_slot, 0);
    rst_n = 1'b1;
    // R2: five loads in program order
    for (int n = 1; n <= 5; n++) step(1, blk(n, 4), 0, 0, '0);
    // R5: other block, no flush; same block other offset hits
    step(0, '0, 0, 1, blk(100, 4));
    step(0, '0, 0, 1, blk(3, 60));
    // R10: load in the same cycle as a hit is dropped
    step(1, blk(7, 0), 0, 1, blk(2, 8));
    idle();
    // R7: older entry stays tracked
    step(0, '0, 0, 1, blk(1, 0));
    idle();
    // R6: oldest of two loads in one block is named
    step(1, blk(9, 0), 0, 0, '0);
    step(1, blk(9, 32), 0, 0, '0);
    step(1, blk(10, 0), 0, 0, '0);
    step(0, '0, 0, 1, blk(9, 16));
    idle();
    // R8: commit beats snoop on the head; R9: retired load no longer tracked
    step(1, blk(11, 0), 0, 0, '0);
    step(1, blk(12, 0), 0, 0, '0);
    step(0, '0, 1, 1, blk(11, 0));
    step(0, '0, 0, 1, blk(11, 0));
    step(0, '0, 1, 0, '0);
    idle();
    // R3: fill to 16, extra load dropped and not tracked
    for (int n = 20; n < 36; n++) step(1, blk(n, 0), 0, 0, '0);
    step(1, blk(40, 0), 0, 0, '0);
    step(0, '0, 0, 1, blk(40, 0));
    // R8: commit of head plus younger match still flushes
    step(0, '0, 1, 1, blk(33, 0));
    idle();
    // R4: drain, commit on empty, wrap of slots
    for (int i = 0; i < 14; i++) step(0, '0, 1, 0, '0);
    step(0, '0, 1, 0, '0);
    step(1, blk(50, 0), 0, 0, '0);
    step(1, blk(51, 0), 0, 0, '0);
    step(0, '0, 0, 1, blk(51, 0));
    idle();
    idle();
    finish_run();
  end
endmodule